// File: doc/BRIEF.md
# Phase-Accumulator Multi-Waveform Oscillator

This block is a single tone-generator voice that advances once per system clock. A 24-bit phase accumulator adds a 16-bit frequency word every cycle. The top bits of the phase give sawtooth, triangle and pulse shapes. A 23-bit linear feedback shift register, stepped by the phase, gives a noise shape. A control byte selects the shape. The same byte also carries a test bit, which halts and clears the voice, and two coupling bits that tie this voice to a paired source voice.

The coupling reaches the voice through sideband inputs driven by the source voice: the source's phase MSB, its MSB-rising strobe, and a flag saying the source was hard-synced itself in the current cycle. The voice drives the matching outputs for its own destination, so three voices can be wired in a ring. The selected 12-bit sample is presented every cycle. An 8-bit readback of its upper bits is also provided.

Top module: `wave_osc_voice`

## Requirements
- R1: While the test bit is clear, the phase adds `freqWord` every cycle modulo 2^24. With waveform code 2 (sawtooth), `waveOut` equals phase bits 23:12, so the sawtooth repeats every 2^24/freq cycles.
- R2: Control byte fields: bits 7:4 are the waveform code (bit4 triangle, bit5 sawtooth, bit6 pulse, bit7 noise), bit3 is test, bit2 is ring, bit1 is sync. Bit0 has no effect on any output.
- R3: Reset leaves the phase at 0 and the noise register at 0x7FFFF8. While test is set, the phase and the noise register are held at 0. In the cycle after test is cleared, the noise register holds 0x7FFFF8.
- R4: Each time phase bit 19 goes from 0 to 1, the noise register shifts left by one bit. The new bit 0 is bit 22 XOR bit 17.
- R5: With code 8 (noise), `waveOut[11:4]` equals noise register bits 22, 20, 16, 13, 11, 7, 4 and 2, in that order. `waveOut[3:0]` is 0.
- R6: With code 1 (triangle), `waveOut` is phase bits 22:11, inverted when the selected MSB is 1. The selected MSB is phase bit 23, XORed with `srcMsb` when ring is set.
- R7: With code 4 (pulse), `waveOut` is 0xFFF when test is set or when phase bits 23:12 are at least `pulseWidth`. Otherwise it is 0x000.
- R8: When sync is set, `srcRise` is high and `srcSynced` is low, the phase is 0 after the clock edge. When `srcSynced` is high, the normal update is kept.
- R9: `msbRise` is high in exactly those cycles whose closing edge takes phase bit 23 from 0 to 1 in the normal update. `syncTaken` is high when sync is set and `srcRise` is high.
- R10: `oscRead` equals `waveOut[11:4]`.
- R11: Codes other than 0, 1, 2, 4 and 8 give `waveOut` = 0. Code 0 also gives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| freqWord | input | 16 | Phase increment per cycle |
| pulseWidth | input | 12 | Pulse threshold |
| ctrlByte | input | 8 | Waveform code, test, ring, sync, gate (ignored) |
| srcMsb | input | 1 | Source voice phase MSB (ring) |
| srcRise | input | 1 | Source voice MSB-rising strobe |
| srcSynced | input | 1 | Source voice was hard-synced this cycle |
| waveOut | output | 12 | Selected waveform sample |
| oscRead | output | 8 | Upper 8 bits of the sample |
| msbMon | output | 1 | Own phase MSB, for a ring-modulated destination |
| msbRise | output | 1 | Own MSB-rising strobe |
| syncTaken | output | 1 | Own sync condition, for a destination's suppression check |

## Verification
The assertions assume that `srcRise` can only rise in a cycle that follows a cycle without it. A real source voice guarantees this, because its increment is below 2^23. The assertions also assume that the control inputs hold steady for at least one cycle around a test-bit change. The random stimulus respects the first assumption by drawing the strobe with no more than occasional pulses. It respects the second by changing the control byte only at clock-low times and keeping each value for several cycles. The stimulus draws the frequency word below 2^16, which keeps the bit-19 crossing to at most one per cycle. The reference model depends on that limit.

// File: rtl/wave_osc_pkg.sv
package wave_osc_pkg;
  localparam int LFSR_W = 23;
  localparam logic [LFSR_W-1:0] LFSR_SEED = 23'h7FFFF8;

  typedef struct packed {
    logic clearAll;    // test level: hold phase and noise at zero
    logic noiseReload; // test just released: reload seed
    logic syncClear;   // hard sync: zero the phase after update
  } osc_strobe_t;

  typedef struct packed {
    logic [3:0] shape;
    logic       test;
    logic       ring;
    logic       sync;
    logic       gate;
  } osc_ctrl_t;
endpackage

// File: rtl/wave_osc_ctrl.sv
module wave_osc_ctrl
  import wave_osc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [7:0]  ctrlByte,
  input  logic        srcRise,
  input  logic        srcSynced,
  output osc_strobe_t strobes,
  output logic [3:0]  shapeSel,
  output logic        ringEn,
  output logic        syncTaken
);
  osc_ctrl_t fields;
  logic      testPrev;

  assign fields = osc_ctrl_t'(ctrlByte);

  always_ff @(posedge clk) begin
    if (!rstN) testPrev <= 1'b0;
    else       testPrev <= fields.test;
  end

  always_comb begin
    strobes.clearAll    = fields.test;
    strobes.noiseReload = testPrev && !fields.test;
    strobes.syncClear   = fields.sync && srcRise && !srcSynced && !fields.test;
  end

  assign shapeSel  = fields.shape;
  assign ringEn    = fields.ring;
  assign syncTaken = fields.sync && srcRise;
endmodule

// File: rtl/wave_osc_dp.sv
module wave_osc_dp
  import wave_osc_pkg::*;
#(
  parameter int FREQ_W = 16,
  parameter int ACC_W  = 24,
  parameter int PW_W   = 12,
  parameter int OUT_W  = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [FREQ_W-1:0] freqWord,
  input  logic [PW_W-1:0]   pulseWidth,
  input  osc_strobe_t       strobes,
  input  logic [3:0]        shapeSel,
  input  logic              ringEn,
  input  logic              srcMsb,
  output logic [OUT_W-1:0]  waveOut,
  output logic              msbRise,
  output logic [ACC_W-1:0]  accQ,
  output logic [LFSR_W-1:0] lfsrQ
);
  localparam int NOISE_BIT = ACC_W - 5;
  localparam int NOISE_TAPS = 8;
  localparam int TAP_POS [NOISE_TAPS] = '{22, 20, 16, 13, 11, 7, 4, 2};

  logic [ACC_W-1:0]  accNext;
  logic              noiseStep;
  logic [LFSR_W-1:0] lfsrShift;
  logic [OUT_W-1:0]  sawWave, triWave, pulseWave, noiseWave;
  logic              triMsb;

  assign accNext   = accQ + ACC_W'(freqWord);
  assign noiseStep = !accQ[NOISE_BIT] && accNext[NOISE_BIT];
  assign msbRise   = !strobes.clearAll && !accQ[ACC_W-1] && accNext[ACC_W-1];
  assign lfsrShift = {lfsrQ[LFSR_W-2:0], lfsrQ[22] ^ lfsrQ[17]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accQ  <= '0;
      lfsrQ <= LFSR_SEED;
    end else if (strobes.clearAll) begin
      accQ  <= '0;
      lfsrQ <= '0;
    end else begin
      accQ <= strobes.syncClear ? '0 : accNext;
      if (strobes.noiseReload)  lfsrQ <= LFSR_SEED;
      else if (noiseStep)       lfsrQ <= lfsrShift;
    end
  end

  assign sawWave   = accQ[ACC_W-1 -: OUT_W];
  assign triMsb    = accQ[ACC_W-1] ^ (ringEn & srcMsb);
  assign triWave   = triMsb ? ~accQ[ACC_W-2 -: OUT_W] : accQ[ACC_W-2 -: OUT_W];
  assign pulseWave = (strobes.clearAll || (sawWave >= OUT_W'(pulseWidth))) ? '1 : '0;

  assign noiseWave[OUT_W-NOISE_TAPS-1:0] = '0;
  for (genvar t = 0; t < NOISE_TAPS; t++) begin : g_noiseTap
    assign noiseWave[OUT_W-1-t] = lfsrQ[TAP_POS[t]];
  end

  always_comb begin
    unique case (shapeSel)
      4'h1:    waveOut = triWave;
      4'h2:    waveOut = sawWave;
      4'h4:    waveOut = pulseWave;
      4'h8:    waveOut = noiseWave;
      default: waveOut = '0;
    endcase
  end
endmodule

// File: rtl/wave_osc_voice.sv
module wave_osc_voice
  import wave_osc_pkg::*;
#(
  parameter int FREQ_W = 16,
  parameter int ACC_W  = 24,
  parameter int PW_W   = 12,
  parameter int OUT_W  = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [FREQ_W-1:0] freqWord,
  input  logic [PW_W-1:0]   pulseWidth,
  input  logic [7:0]        ctrlByte,
  input  logic              srcMsb,
  input  logic              srcRise,
  input  logic              srcSynced,
  output logic [OUT_W-1:0]  waveOut,
  output logic [7:0]        oscRead,
  output logic              msbMon,
  output logic              msbRise,
  output logic              syncTaken
);
  osc_strobe_t       strobes;
  logic [3:0]        shapeSel;
  logic              ringEn;
  logic [ACC_W-1:0]  accQ;
  logic [LFSR_W-1:0] lfsrQ;

  wave_osc_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .ctrlByte(ctrlByte), .srcRise(srcRise),
    .srcSynced(srcSynced), .strobes(strobes), .shapeSel(shapeSel),
    .ringEn(ringEn), .syncTaken(syncTaken)
  );

  wave_osc_dp #(.FREQ_W(FREQ_W), .ACC_W(ACC_W), .PW_W(PW_W), .OUT_W(OUT_W)) u_dp (
    .clk(clk), .rstN(rstN), .freqWord(freqWord), .pulseWidth(pulseWidth),
    .strobes(strobes), .shapeSel(shapeSel), .ringEn(ringEn), .srcMsb(srcMsb),
    .waveOut(waveOut), .msbRise(msbRise), .accQ(accQ), .lfsrQ(lfsrQ)
  );

  assign oscRead = waveOut[OUT_W-1 -: 8];
  assign msbMon  = accQ[ACC_W-1];
endmodule

// File: rtl/wave_osc_voice_chk.sv
module wave_osc_voice_chk
  import wave_osc_pkg::*;
#(
  parameter int ACC_W = 24,
  parameter int OUT_W = 12
) (
  input logic              clk,
  input logic              rstN,
  input logic [7:0]        ctrlByte,
  input logic              srcRise,
  input logic              srcSynced,
  input logic [OUT_W-1:0]  waveOut,
  input logic              msbRise,
  input logic [ACC_W-1:0]  accQ,
  input logic [LFSR_W-1:0] lfsrQ
);
  logic pastValid;
  always_ff @(posedge clk) begin
    if (!rstN) pastValid <= 1'b0;
    else       pastValid <= 1'b1;
  end

  // R3: a held test bit leaves phase and noise at zero
  a_r3_test_clears: assert property (@(posedge clk) disable iff (!rstN)
    ctrlByte[3] |=> (accQ == '0 && lfsrQ == '0));

  // R3: releasing test reloads the noise seed
  a_r3_seed_reload: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && $past(ctrlByte[3]) && !ctrlByte[3]) |=> (lfsrQ == LFSR_SEED));

  // R7: test forces pulse high
  a_r7_pulse_test: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlByte[3] && ctrlByte[7:4] == 4'h4) |-> (waveOut == '1));

  // R8: hard sync zeroes the phase
  a_r8_sync_zero: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlByte[1] && srcRise && !srcSynced && !ctrlByte[3]) |=> (accQ == '0));

  // R9: the rising strobe never lasts two cycles
  a_r9_rise_single: assert property (@(posedge clk) disable iff (!rstN)
    msbRise |=> !msbRise);

  // R11: combined codes are silent
  a_r11_combo_zero: assert property (@(posedge clk) disable iff (!rstN)
    (!$onehot0(ctrlByte[7:4])) |-> (waveOut == '0));
endmodule

bind wave_osc_voice wave_osc_voice_chk #(.ACC_W(ACC_W), .OUT_W(OUT_W)) i_chk (
  .clk(clk), .rstN(rstN), .ctrlByte(ctrlByte), .srcRise(srcRise),
  .srcSynced(srcSynced), .waveOut(waveOut), .msbRise(msbRise),
  .accQ(accQ), .lfsrQ(lfsrQ)
);

// File: tb/test_wave_osc_voice.sv
`timescale 1ns/1ps
module test_wave_osc_voice;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] freqWord = '0;
  logic [11:0] pulseWidth = '0;
  logic [7:0]  ctrlByte = '0;
  logic        srcMsb = 1'b0, srcRise = 1'b0, srcSynced = 1'b0;
  logic [11:0] waveOut;
  logic [7:0]  oscRead;
  logic        msbMon, msbRise, syncTaken;

  int checks = 0;
  int errors = 0;

  // reference state
  logic [23:0] mAcc = '0;
  logic [22:0] mLfsr = 23'h7FFFF8;
  logic        mTestPrev = 1'b0;

  always #2.5 clk = ~clk;

  wave_osc_voice i_wave_osc_voice (
    .clk(clk), .rstN(rstN), .freqWord(freqWord), .pulseWidth(pulseWidth),
    .ctrlByte(ctrlByte), .srcMsb(srcMsb), .srcRise(srcRise), .srcSynced(srcSynced),
    .waveOut(waveOut), .oscRead(oscRead), .msbMon(msbMon), .msbRise(msbRise),
    .syncTaken(syncTaken)
  );

  function automatic logic [11:0] expWave(logic [23:0] a, logic [22:0] l,
                                          logic [7:0] c, logic [11:0] pw, logic sm);
    logic m;
    m = a[23] ^ (c[2] & sm);
    case (c[7:4])
      4'h1: return m ? ~a[22:11] : a[22:11];
      4'h2: return a[23:12];
      4'h4: return (c[3] || a[23:12] >= pw) ? 12'hFFF : 12'h000;
      4'h8: return {l[22], l[20], l[16], l[13], l[11], l[7], l[4], l[2], 4'h0};
      default: return 12'h000;
    endcase
  endfunction

  function automatic string tagFor(logic [3:0] code);
    case (code)
      4'h1: return "R6";
      4'h2: return "R1";
      4'h4: return "R7";
      4'h8: return "R5";
      default: return "R11";
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // compare outputs for the present state and inputs, then advance one edge
  task automatic step();
    logic [23:0] nxt;
    logic        expRise;
    #1;
    nxt = mAcc + {8'h0, freqWord};
    expRise = !ctrlByte[3] && !mAcc[23] && nxt[23];
    check(tagFor(ctrlByte[7:4]), waveOut,
          expWave(mAcc, mLfsr, ctrlByte, pulseWidth, srcMsb));
    check("R10", oscRead, waveOut[11:4]);
    check("R9", msbRise, expRise);
    check("R9", syncTaken, ctrlByte[1] && srcRise);
    @(posedge clk);
    if (ctrlByte[3]) begin
      mAcc = '0; mLfsr = '0;
    end else begin
      if (mTestPrev) mLfsr = 23'h7FFFF8;
      else if (!mAcc[19] && nxt[19]) mLfsr = {mLfsr[21:0], mLfsr[22] ^ mLfsr[17]};
      mAcc = (ctrlByte[1] && srcRise && !srcSynced) ? 24'h0 : nxt;
    end
    mTestPrev = ctrlByte[3];
    @(negedge clk);
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(5.0 * 190000);
    errors++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    int period;
    int lastRise;
    void'($urandom(32'h5EED_1234));
    repeat (4) @(negedge clk);
    rstN = 1'b1;

    // R3: reset state through the sawtooth and noise views
    ctrlByte = 8'h20; step();
    check("R3", waveOut, 12'h000);
    ctrlByte = 8'h80; step();
    check("R3", waveOut, 12'hFE0);

    // R1: sawtooth period 2^24/4096 cycles
    ctrlByte = 8'h28; step(); step();
    freqWord = 16'h1000; ctrlByte = 8'h20;
    lastRise = -1; period = 0;
    for (int i = 0; i < 9000; i++) begin
      if (msbRise) begin
        if (lastRise >= 0) period = i - lastRise;
        lastRise = i;
      end
      step();
    end
    check("R1", period, 4096);

    // R4/R5: noise sequence at a fast bit-19 rate, gate toggling (R2)
    ctrlByte = 8'h88; step(); step();
    freqWord = 16'hC000; ctrlByte = 8'h80;
    for (int i = 0; i < 4000; i++) begin
      ctrlByte[0] = i[3];
      step();
    end

    // R8: directed hard sync, then suppression
    ctrlByte = 8'h22; freqWord = 16'h0100;
    repeat (50) step();
    srcRise = 1'b1; step(); srcRise = 1'b0;
    check("R8", waveOut, 12'h000);
    repeat (50) step();
    srcRise = 1'b1; srcSynced = 1'b1; step(); srcRise = 1'b0; srcSynced = 1'b0;
    check("R8", waveOut == 12'h000, 1'b0);

    // R6/R7: triangle with ring, pulse with test
    ctrlByte = 8'h14; srcMsb = 1'b1; repeat (200) step();
    ctrlByte = 8'h48; repeat (3) step();
    check("R7", waveOut, 12'hFFF);

    // constrained random mix
    for (int blk = 0; blk < 2500; blk++) begin
      logic [3:0] shape;
      case ($urandom_range(0, 6))
        0: shape = 4'h1; 1: shape = 4'h2; 2: shape = 4'h4; 3: shape = 4'h8;
        4: shape = 4'h0; default: shape = 4'($urandom_range(0, 15));
      endcase
      freqWord   = 16'($urandom);
      pulseWidth = 12'($urandom);
      ctrlByte   = {shape, ($urandom_range(0, 19) == 0), 1'($urandom),
                    1'($urandom), 1'($urandom)};
      srcMsb     = 1'($urandom);
      for (int k = 0; k < 6; k++) begin
        srcRise   = ($urandom_range(0, 7) == 0) && !srcRise;
        srcSynced = 1'($urandom);
        step();
      end
      srcRise = 1'b0;
    end
    finishRun();
  end
endmodule